// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Node

This block is one link in a prioritised interrupt chain. It owns a small set of internal interrupt sources. Each source has an enable, a pending bit and an in-service bit, and the whole node has one master enable. Index 0 is the most urgent source. The node pulls a shared active-low request line whenever one of its sources may interrupt. It passes a chain enable signal on to less urgent nodes when it has no claim of its own, and withholds that signal when it does.

The processor answers a request with an acknowledge cycle. The acknowledge and read strobes are synchronised into the clock domain. After the acknowledge has been seen, a fixed number of clock cycles is allowed for the chain to settle. The node then samples the read strobe. If its chain enable input is still high at that point, it marks its most urgent requesting source as in service. An in-service bit locks out that source and every less urgent source, both in this node and further down the chain. It stays set until software issues a clear-highest-in-service command or resets the node.

A system without an acknowledge cycle ties the acknowledge input high. Sources then only raise and drop the request line, and no in-service bit is ever set.

Top module: `irq_chain_node`

## Requirements
- R1: While no in-service bit is set and no acknowledge cycle is active, `chain_en_o` equals `chain_en_i`, including when sources are pending.
- R2: `irq_no` is 0 exactly when some source i has pending=1, its enable=1, master enable=1, in-service bit i=0 and no in-service bit of lower index set, and no acknowledge cycle is active; otherwise it is 1.
- R3: While the synchronised acknowledge (`ack_ni` low) is active, `irq_no` is 1.
- R4: While acknowledge is active and any enabled source of the node is pending, `chain_en_o` is 0.
- R5: While any in-service bit is set, `chain_en_o` is 0, inside or outside an acknowledge cycle.
- R6: In an acknowledge cycle, once the settle time has elapsed and `rd_ni` is low, a node with `chain_en_i`=1 sets the in-service bit of its lowest-index requesting source, and only that one. With `chain_en_i`=0 it sets none.
- R7: No in-service bit is set within SYNC_STAGES+SETTLE_CYC clock edges after `ack_ni` falls, even if `rd_ni` fell at the same time.
- R8: A pulse on `clr_ius_i` clears only the lowest-index set in-service bit.
- R9: An in-service bit is cleared only by `clr_ius_i`, `sw_rst_i` or `rst_ni`. Clearing the pending bit of the same source leaves the in-service bit set. `sw_rst_i` clears all pending and in-service bits.
- R10: `pend_set_i[i]` sets pending bit i and `pend_clr_i[i]` clears it, with set winning when both pulse. Clearing one pending bit releases `irq_no` only if no other source still requests.
- R11: A pending source blocked by a more urgent in-service bit keeps its pending bit. It requests once that in-service bit is cleared.
- R12: With `ack_ni` held high, pulses on `rd_ni` set no in-service bit.
- R13: After reset, `pend_o` and `ius_o` are 0, `irq_no` is 1, and `chain_en_o` follows `chain_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_rst_i | input | 1 | Synchronous software reset of pending and in-service bits |
| mst_en_i | input | 1 | Master interrupt enable |
| src_en_i | input | NUM_SRC | Per-source interrupt enable |
| pend_set_i | input | NUM_SRC | Per-source pending set strobe |
| pend_clr_i | input | NUM_SRC | Per-source pending clear strobe |
| clr_ius_i | input | 1 | Clear lowest-index (most urgent) in-service bit |
| ack_ni | input | 1 | Acknowledge cycle, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| chain_en_i | input | 1 | Chain enable from the more urgent neighbour |
| chain_en_o | output | 1 | Chain enable to the less urgent neighbour |
| irq_no | output | 1 | Interrupt request, active low |
| pend_o | output | NUM_SRC | Pending bits |
| ius_o | output | NUM_SRC | In-service bits |

## Verification
The bench builds the node with NUM_SRC=4, SYNC_STAGES=2 and SETTLE_CYC=3. With these values the settle window is short enough to probe just before and well after it. Four sources are enough to have two in-service bits held at once with a blocked pending source between them, so the clear command and lockout can be checked at distinct priorities. Driving `chain_en_i` low during a full acknowledge cycle shows that a node denied the chain claims nothing.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE   = 2'd0,
    ACK_SETTLE = 2'd1,
    ACK_ARMED  = 2'd2,
    ACK_HOLD   = 2'd3
  } ack_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [STAGES-1:0][WIDTH-1:0] stg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q <= {STAGES{RST_VAL}};
      end else begin
        stg_q[0] <= d_i;
        for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
    end
    assign q_o = stg_q[STAGES-1];
  end
endmodule

// File: rtl/irq_prio_pick.sv
// Lowest index wins. above_o[i] flags any set bit of lower index.
module irq_prio_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] first_o,
  output logic [N-1:0] above_o
);
  assign above_o[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_above
    assign above_o[i] = above_o[i-1] | vec_i[i-1];
  end
  assign first_o = vec_i & ~above_o;
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_chain_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_rst_i,
  input  logic ack_act_i,
  input  logic rd_act_i,
  output logic sample_o
);
  localparam int unsigned CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W:0] LAST = (SETTLE_CYC == 0) ? '0 : (CNT_W+1)'(SETTLE_CYC - 1);

  ack_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (sw_rst_i || !ack_act_i) begin
      st_d  = ACK_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ACK_IDLE: begin
          st_d  = ACK_SETTLE;
          cnt_d = '0;
        end
        ACK_SETTLE: begin
          if ({1'b0, cnt_q} >= LAST) st_d = ACK_ARMED;
          else cnt_d = cnt_q + 1'b1;
        end
        ACK_ARMED: if (rd_act_i) st_d = ACK_HOLD;
        ACK_HOLD:  st_d = ACK_HOLD;
        default:   st_d = ACK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ACK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign sample_o = (st_q == ACK_ARMED) && ack_act_i && rd_act_i && !sw_rst_i;
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_rst_i,
  input  logic [NUM_SRC-1:0] pend_set_i,
  input  logic [NUM_SRC-1:0] pend_clr_i,
  input  logic [NUM_SRC-1:0] ius_set_i,
  input  logic               ius_clr_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] ius_o,
  output logic [NUM_SRC-1:0] ius_above_o
);
  logic [NUM_SRC-1:0] pend_q, ius_q, ius_first;

  irq_prio_pick #(.N(NUM_SRC)) u_ius_pick (
    .vec_i   (ius_q),
    .first_o (ius_first),
    .above_o (ius_above_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ius_q  <= '0;
    end else if (sw_rst_i) begin
      pend_q <= '0;
      ius_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr_i) | pend_set_i;
      ius_q  <= (ius_q & ~(ius_clr_i ? ius_first : '0)) | ius_set_i;
    end
  end

  assign pend_o = pend_q;
  assign ius_o  = ius_q;
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node #(
  parameter int unsigned NUM_SRC     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETTLE_CYC  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_rst_i,
  input  logic               mst_en_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [NUM_SRC-1:0] pend_set_i,
  input  logic [NUM_SRC-1:0] pend_clr_i,
  input  logic               clr_ius_i,
  input  logic               ack_ni,
  input  logic               rd_ni,
  input  logic               chain_en_i,
  output logic               chain_en_o,
  output logic               irq_no,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] ius_o
);
  logic [1:0]         strb_s;
  logic               ack_act, rd_act, sample;
  logic [NUM_SRC-1:0] en_eff, req, req_first, req_above, ius_above, ius_set;
  logic               any_req, win;

  irq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ack_ni, rd_ni}),
    .q_o    (strb_s)
  );
  assign ack_act = ~strb_s[1];
  assign rd_act  = ~strb_s[0];

  irq_ack_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_rst_i  (sw_rst_i),
    .ack_act_i (ack_act),
    .rd_act_i  (rd_act),
    .sample_o  (sample)
  );

  irq_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_rst_i    (sw_rst_i),
    .pend_set_i  (pend_set_i),
    .pend_clr_i  (pend_clr_i),
    .ius_set_i   (ius_set),
    .ius_clr_i   (clr_ius_i),
    .pend_o      (pend_o),
    .ius_o       (ius_o),
    .ius_above_o (ius_above)
  );

  assign en_eff  = src_en_i & {NUM_SRC{mst_en_i}};
  assign req     = pend_o & en_eff & ~ius_o & ~ius_above;
  assign any_req = |req;

  irq_prio_pick #(.N(NUM_SRC)) u_req_pick (
    .vec_i   (req),
    .first_o (req_first),
    .above_o (req_above)
  );

  assign win     = sample & chain_en_i & any_req;
  assign ius_set = win ? req_first : '0;

  assign irq_no     = ~(any_req & ~ack_act);
  assign chain_en_o = chain_en_i & ~(|ius_o) & ~(ack_act & |(pend_o & en_eff));

  logic unused_ok;
  assign unused_ok = ^req_above;
endmodule

// File: rtl/irq_chain_node_chk.sv
module irq_chain_node_chk #(
  parameter int unsigned NUM_SRC = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sw_rst_i,
  input logic               clr_ius_i,
  input logic               chain_en_i,
  input logic               chain_en_o,
  input logic               irq_no,
  input logic [NUM_SRC-1:0] ius_o,
  input logic               ack_act
);
  AST_IUS_SET_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ius_o & ~$past(ius_o))) |-> $past(ack_act && chain_en_i)); // R6

  AST_IUS_SET_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ius_o & ~$past(ius_o)) <= 1); // R6

  AST_IUS_CLR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(ius_o) & ~ius_o)) |-> $past(clr_ius_i || sw_rst_i)); // R9

  AST_IRQ_QUIET_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_act |-> irq_no); // R3

  AST_BLOCK_IUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ius_o) |-> !chain_en_o); // R5

  AST_PASS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ius_o == '0 && !ack_act) |-> (chain_en_o == chain_en_i)); // R1
endmodule

bind irq_chain_node irq_chain_node_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sw_rst_i   (sw_rst_i),
  .clr_ius_i  (clr_ius_i),
  .chain_en_i (chain_en_i),
  .chain_en_o (chain_en_o),
  .irq_no     (irq_no),
  .ius_o      (ius_o),
  .ack_act    (ack_act)
);

// File: tb/irq_chain_node_test.sv
`timescale 1ns/1ps
module irq_chain_node_test;
  localparam int N = 4;

  typedef enum logic [1:0] {K_IRQ, K_CEO, K_PEND, K_IUS} kind_e;
  typedef struct {
    kind_e      kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw_rst_i = 1'b0, mst_en_i = 1'b0, clr_ius_i = 1'b0;
  logic ack_ni = 1'b1, rd_ni = 1'b1, chain_en_i = 1'b1;
  logic [N-1:0] src_en_i = '0, pend_set_i = '0, pend_clr_i = '0;
  logic chain_en_o, irq_no;
  logic [N-1:0] pend_o, ius_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #2 clk = ~clk;

  irq_chain_node #(.NUM_SRC(N), .SYNC_STAGES(2), .SETTLE_CYC(3)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sw_rst_i(sw_rst_i), .mst_en_i(mst_en_i),
    .src_en_i(src_en_i), .pend_set_i(pend_set_i), .pend_clr_i(pend_clr_i),
    .clr_ius_i(clr_ius_i), .ack_ni(ack_ni), .rd_ni(rd_ni),
    .chain_en_i(chain_en_i), .chain_en_o(chain_en_o), .irq_no(irq_no),
    .pend_o(pend_o), .ius_o(ius_o)
  );

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_val(input kind_e k, input logic [7:0] e, input string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    sb_q.push_back(it);
  endtask

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        K_IRQ:   act = {7'd0, irq_no};
        K_CEO:   act = {7'd0, chain_en_o};
        K_PEND:  act = {4'd0, pend_o};
        default: act = {4'd0, ius_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic pulse_set(input logic [N-1:0] m);
    pend_set_i = m; step(); pend_set_i = '0;
  endtask

  task automatic pulse_clr(input logic [N-1:0] m);
    pend_clr_i = m; step(); pend_clr_i = '0;
  endtask

  task automatic pulse_clr_ius();
    clr_ius_i = 1'b1; step(); clr_ius_i = 1'b0;
  endtask

  task automatic ack_cycle();
    ack_ni = 1'b0; rd_ni = 1'b0;
    step(8);
    ack_ni = 1'b1; rd_ni = 1'b1;
    step(4);
  endtask

  initial begin
    step(2);
    // R13 reset state
    expect_val(K_IRQ, 8'h01, "R13"); expect_val(K_PEND, 8'h00, "R13");
    expect_val(K_IUS, 8'h00, "R13"); expect_val(K_CEO, 8'h01, "R13");
    step();
    rst_ni = 1'b1; step();
    chain_en_i = 1'b0; #0;
    expect_val(K_CEO, 8'h00, "R1"); step();
    chain_en_i = 1'b1;
    mst_en_i = 1'b1; src_en_i = 4'b1111;

    // R2 request on source 2
    pulse_set(4'b0100); step();
    expect_val(K_PEND, 8'h04, "R10"); expect_val(K_IRQ, 8'h00, "R2");
    expect_val(K_CEO, 8'h01, "R1"); step();
    mst_en_i = 1'b0; #0;
    expect_val(K_IRQ, 8'h01, "R2"); step();
    mst_en_i = 1'b1; #0;
    src_en_i = 4'b1011; #0;
    expect_val(K_IRQ, 8'h01, "R2"); step();
    src_en_i = 4'b1111;

    // R3/R4/R7 acknowledge with read low at the same time
    ack_ni = 1'b0; rd_ni = 1'b0;
    step(3);
    expect_val(K_IRQ, 8'h01, "R3"); expect_val(K_CEO, 8'h00, "R4");
    expect_val(K_IUS, 8'h00, "R7");
    step(2);
    expect_val(K_IUS, 8'h00, "R7");
    step(3);
    expect_val(K_IUS, 8'h04, "R6"); expect_val(K_PEND, 8'h04, "R6");
    ack_ni = 1'b1; rd_ni = 1'b1;
    step(4);
    expect_val(K_CEO, 8'h00, "R5"); expect_val(K_IRQ, 8'h01, "R2");
    step();

    // R11 lower source blocked, higher still requests
    pulse_set(4'b1000); step();
    expect_val(K_IRQ, 8'h01, "R11"); expect_val(K_PEND, 8'h0C, "R11");
    step();
    pulse_set(4'b0011); step();
    expect_val(K_IRQ, 8'h00, "R2");
    pulse_clr(4'b0001); step();
    expect_val(K_IRQ, 8'h00, "R10");
    pulse_clr(4'b0010); step();
    expect_val(K_IRQ, 8'h01, "R10");
    // R9 pending clear does not touch in-service
    pulse_clr(4'b0100); step();
    expect_val(K_IUS, 8'h04, "R9"); expect_val(K_PEND, 8'h08, "R9");
    step();
    pulse_clr_ius(); step();
    expect_val(K_IUS, 8'h00, "R8"); expect_val(K_IRQ, 8'h00, "R11");
    expect_val(K_CEO, 8'h01, "R1");
    step();

    // Two in-service bits, then clear order (R8)
    ack_cycle();
    expect_val(K_IUS, 8'h08, "R6");
    pulse_set(4'b0010); step();
    expect_val(K_IRQ, 8'h00, "R2");
    ack_cycle();
    expect_val(K_IUS, 8'h0A, "R6");
    pulse_clr_ius(); step();
    expect_val(K_IUS, 8'h08, "R8");
    pulse_clr_ius(); step();
    expect_val(K_IUS, 8'h00, "R8");
    step();

    // R6 chain enable low: nothing claimed
    chain_en_i = 1'b0;
    ack_cycle();
    expect_val(K_IUS, 8'h00, "R6");
    chain_en_i = 1'b1;
    step();
    // R6 priority: pend=1010 -> source 1 chosen
    ack_cycle();
    expect_val(K_IUS, 8'h02, "R6");
    pulse_clr_ius(); step();

    // R12 no-acknowledge mode: read pulses only
    rd_ni = 1'b0; step(10); rd_ni = 1'b1; step(3);
    expect_val(K_IUS, 8'h00, "R12"); expect_val(K_IRQ, 8'h00, "R12");
    step();

    // R10 set wins over clear
    pend_set_i = 4'b0001; pend_clr_i = 4'b0001; step();
    pend_set_i = '0; pend_clr_i = '0;
    expect_val(K_PEND, 8'h0B, "R10");
    step();

    // R9 software reset clears in-service
    ack_cycle();
    expect_val(K_IUS, 8'h01, "R6");
    sw_rst_i = 1'b1; step(); sw_rst_i = 1'b0;
    expect_val(K_IUS, 8'h00, "R9"); expect_val(K_PEND, 8'h00, "R9");
    expect_val(K_IRQ, 8'h01, "R9");
    step(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule